// File: doc/BRIEF.md
# DMA Transfer-Complete Flag Bank

This block keeps one transfer-complete flag for each of the eight streams of a DMA controller. Each stream's transfer logic sends a one-cycle completion pulse. The pulse sets that stream's flag. If the stream's complete-interrupt enable is high in the same cycle, the pulse also raises that stream's interrupt line.

Software sees the flags through a small word-addressed register port. Two read-only status words each carry four streams, at bit positions 5, 11, 21 and 27. Two write-one-to-clear words use the same bit layout. Writing a 1 to a stream's bit in a clear word drops both the flag and the interrupt line of that stream. Read data is combinational from the address, so a read returns the flag state as it stands after the latest clock edge.

Top module: `dmaflag_top`

## Requirements
- R1: After synchronous reset, every flag is clear, every interrupt line is low and all four words read as zero.
- R2: A completion pulse on stream 0, 1, 2 or 3 sets a flag that reads as 1 in the status word at offset 0x0, at bit 5, 11, 21 or 27 respectively, from the clock edge that samples the pulse onward.
- R3: Streams 4, 5, 6 and 7 report at bits 5, 11, 21 and 27 of the status word at offset 0x4. A flag never appears in the other status word.
- R4: In both status words, every bit other than 5, 11, 21 and 27 reads as zero.
- R5: Writing to offset 0x8 clears streams 0–3, and writing to offset 0xC clears streams 4–7. A 1 at a stream's bit position clears that stream's flag and drops its interrupt line. Bits written as 0 leave their streams unchanged.
- R6: An interrupt line goes high only at a completion pulse that arrives while that stream's enable input is high. If the enable is low at completion, the flag is still set but the line stays low. Raising the enable later does not raise the line.
- R7: If a completion pulse and a clear for the same stream arrive in the same cycle, the flag ends set, and the interrupt line follows R6.
- R8: Writes to the status words at 0x0 and 0x4 change no flag and no interrupt line.
- R9: The clear words at 0x8 and 0xC, and any offset whose two low bits are not zero, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 8 | Per-stream completion pulse |
| irq_en_i | input | 8 | Per-stream complete-interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte offset of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 8 | Per-stream interrupt line |

## Verification
The hardest case to reach from the ports is the same-cycle collision between a completion pulse and a clear write for the same stream. It needs the pulse and the clear-word write to be launched in exactly the same clock window. The bench drives both from a single task call on one falling edge, for a stream that is already flagged. It then reads the status word to confirm that the set won. Partial clears and enable-low completions are also driven, to separate the flag from the interrupt line.

// File: rtl/dmaflag_pkg.sv
package dmaflag_pkg;

    localparam int NUM_STREAMS      = 8;
    localparam int STREAMS_PER_WORD = 4;
    localparam int NUM_WORDS        = NUM_STREAMS / STREAMS_PER_WORD;
    localparam int DATA_W           = 32;
    localparam int ADDR_W           = 4;

    typedef enum logic [1:0] {
        SLOT_STAT_LO = 2'd0,
        SLOT_STAT_HI = 2'd1,
        SLOT_CLR_LO  = 2'd2,
        SLOT_CLR_HI  = 2'd3
    } slot_e;

    typedef struct packed {
        logic  hit;
        slot_e slot;
    } decode_t;

    // bit position of the k-th stream inside a status/clear word
    function automatic int unsigned flag_bit(input int unsigned k);
        case (k)
            0:       return 5;
            1:       return 11;
            2:       return 21;
            default: return 27;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] stat_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < STREAMS_PER_WORD; k++) m[flag_bit(k)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dmaflag_decode.sv
module dmaflag_decode
    import dmaflag_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output decode_t                dec,
    output logic [NUM_STREAMS-1:0] clr
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_comb begin
        dec.hit  = (addr[1:0] == 2'b00);
        dec.slot = slot_e'(addr[3:2]);
    end

    always_comb begin
        int base;
        clr  = '0;
        base = (dec.slot == SLOT_CLR_HI) ? STREAMS_PER_WORD : 0;
        if (wr_en && dec.hit && (dec.slot == SLOT_CLR_LO || dec.slot == SLOT_CLR_HI)) begin
            for (int k = 0; k < STREAMS_PER_WORD; k++)
                clr[base + k] = wdata[flag_bit(k)];
        end
    end

    AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|clr) |-> (wr_en && addr[3])); // R5

    AST_STAT_WRITE_NO_CLR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !addr[3]) |-> (clr == '0)); // R8

endmodule

// File: rtl/dmaflag_bank.sv
module dmaflag_bank
    import dmaflag_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_STREAMS-1:0] done,
    input  logic [NUM_STREAMS-1:0] irq_en,
    input  logic [NUM_STREAMS-1:0] clr,
    output logic [NUM_STREAMS-1:0] flags,
    output logic [NUM_STREAMS-1:0] irq
);
    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[s] <= 1'b0;
                irq[s]   <= 1'b0;
            end else begin
                if (done[s])      flags[s] <= 1'b1;
                else if (clr[s])  flags[s] <= 1'b0;
                if (done[s] && irq_en[s]) irq[s] <= 1'b1;
                else if (clr[s])          irq[s] <= 1'b0;
            end
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            done[s] |=> flags[s]); // R7

        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr[s] && !done[s]) |=> (!flags[s] && !irq[s])); // R5

        AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
            irq[s] |-> flags[s]); // R6

        AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[s]) |-> $past(done[s] && irq_en[s])); // R6
    end

endmodule

// File: rtl/dmaflag_readmux.sv
module dmaflag_readmux
    import dmaflag_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_STREAMS-1:0] flags,
    input  decode_t                dec,
    output logic [DATA_W-1:0]      rdata
);
    logic [NUM_WORDS-1:0][DATA_W-1:0] stat;

    always_comb begin
        stat = '0;
        for (int g = 0; g < NUM_WORDS; g++)
            for (int k = 0; k < STREAMS_PER_WORD; k++)
                stat[g][flag_bit(k)] = flags[g*STREAMS_PER_WORD + k];
    end

    always_comb begin
        rdata = '0;
        if (dec.hit) begin
            case (dec.slot)
                SLOT_STAT_LO: rdata = stat[0];
                SLOT_STAT_HI: rdata = stat[1];
                default:      rdata = '0;
            endcase
        end
    end

    AST_RD_MASK: assert property (@(posedge clk) disable iff (rst)
        ((rdata & ~stat_mask()) == '0)); // R4

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dec.slot == SLOT_CLR_LO || dec.slot == SLOT_CLR_HI || !dec.hit) |-> (rdata == '0)); // R9

endmodule

// File: rtl/dmaflag_top.sv
module dmaflag_top
    import dmaflag_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_STREAMS-1:0] done_i,
    input  logic [NUM_STREAMS-1:0] irq_en_i,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic [DATA_W-1:0]      rdata_o,
    output logic [NUM_STREAMS-1:0] irq_o
);
    decode_t                dec;
    logic [NUM_STREAMS-1:0] clr;
    logic [NUM_STREAMS-1:0] flags;

    dmaflag_decode u_decode (
        .clk(clk), .rst(rst), .wr_en(wr_en_i), .addr(addr_i),
        .wdata(wdata_i), .dec(dec), .clr(clr)
    );

    dmaflag_bank u_bank (
        .clk(clk), .rst(rst), .done(done_i), .irq_en(irq_en_i),
        .clr(clr), .flags(flags), .irq(irq_o)
    );

    dmaflag_readmux u_readmux (
        .clk(clk), .rst(rst), .flags(flags), .dec(dec), .rdata(rdata_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (irq_o == '0)); // R1

endmodule

// File: tb/sim_dmaflag_top.sv
module sim_dmaflag_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  done_i = '0;
    logic [7:0]  irq_en_i = '0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [7:0]  irq_o;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] m_flag = '0;
    logic [7:0] m_irq = '0;

    always #2 clk = ~clk;

    dmaflag_top u0 (.*);

    function automatic int bpos(input int k);
        return (k == 0) ? 5 : (k == 1) ? 11 : (k == 2) ? 21 : 27;
    endfunction

    function automatic logic [31:0] exp_word(input int g);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++) w[bpos(k)] = m_flag[g*4 + k];
        return w;
    endfunction

    function automatic logic [31:0] clr_bits(input logic [3:0] sel);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++) w[bpos(k)] = sel[k];
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // one clock: pulses, enables and an optional write, all launched on a falling edge
    task automatic cycle(input logic [7:0] dn, input logic [7:0] en,
                         input logic wr, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        done_i = dn; irq_en_i = en; wr_en_i = wr; addr_i = a; wdata_i = d;
        @(negedge clk);
        done_i = '0; wr_en_i = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
        addr_i = a;
        #1;
        chk(req, rdata_o, exp);
    endtask

    task automatic t_reset;
        rd("R1", 4'h0, 32'h0); rd("R1", 4'h4, 32'h0);
        rd("R1", 4'h8, 32'h0); rd("R1", 4'hC, 32'h0);
        chk("R1", {24'h0, irq_o}, 32'h0);
    endtask

    task automatic t_low_word;
        cycle(8'h01, 8'hFF, 0, 0, 0);
        cycle(8'h06, 8'hFF, 0, 0, 0);
        cycle(8'h08, 8'hFF, 0, 0, 0);
        m_flag = 8'h0F; m_irq = 8'h0F;
        rd("R2", 4'h0, exp_word(0));
        chk("R2", exp_word(0), 32'h0820_0820);
        rd("R3", 4'h4, 32'h0);
        chk("R6", {24'h0, irq_o}, {24'h0, m_irq});
    endtask

    task automatic t_partial_clear;
        cycle(8'h00, 8'hFF, 1, 4'h8, clr_bits(4'b0101));
        m_flag = 8'h0A; m_irq = 8'h0A;
        rd("R5", 4'h0, exp_word(0));
        chk("R5", {24'h0, irq_o}, {24'h0, m_irq});
        cycle(8'h00, 8'hFF, 1, 4'h8, ~clr_bits(4'b1111));
        rd("R5", 4'h0, exp_word(0));
        cycle(8'h00, 8'hFF, 1, 4'h8, 32'hFFFF_FFFF);
        m_flag = 8'h00; m_irq = 8'h00;
        rd("R5", 4'h0, 32'h0);
        chk("R5", {24'h0, irq_o}, 32'h0);
    endtask

    task automatic t_high_no_irq;
        cycle(8'hA0, 8'h00, 0, 0, 0);
        m_flag = 8'hA0;
        rd("R3", 4'h4, 32'h0800_0800);
        rd("R3", 4'h0, 32'h0);
        chk("R6", {24'h0, irq_o}, 32'h0);
        cycle(8'h00, 8'hFF, 0, 0, 0);
        chk("R6", {24'h0, irq_o}, 32'h0);
    endtask

    task automatic t_mixed_enable;
        cycle(8'hFF, 8'h55, 0, 0, 0);
        m_flag = 8'hFF; m_irq = 8'h55;
        chk("R6", {24'h0, irq_o}, {24'h0, m_irq});
        rd("R4", 4'h0, 32'h0820_0820);
        rd("R4", 4'h4, 32'h0820_0820);
    endtask

    task automatic t_status_write;
        cycle(8'h00, 8'h00, 1, 4'h0, 32'h0);
        cycle(8'h00, 8'h00, 1, 4'h4, 32'hFFFF_FFFF);
        rd("R8", 4'h0, exp_word(0));
        rd("R8", 4'h4, exp_word(1));
        chk("R8", {24'h0, irq_o}, {24'h0, m_irq});
    endtask

    task automatic t_clear_reads_zero;
        rd("R9", 4'h8, 32'h0);
        rd("R9", 4'hC, 32'h0);
        rd("R9", 4'h1, 32'h0);
        rd("R9", 4'h6, 32'h0);
    endtask

    task automatic t_collision;
        // stream 4 flagged with irq; clear it while a new pulse lands in the same cycle
        cycle(8'h10, 8'h10, 1, 4'hC, clr_bits(4'b0011));
        m_flag[4] = 1'b1; m_irq[4] = 1'b1;
        m_flag[5] = 1'b0; m_irq[5] = 1'b0;
        rd("R7", 4'h4, exp_word(1));
        chk("R7", {24'h0, irq_o}, {24'h0, m_irq});
        cycle(8'h00, 8'h00, 1, 4'hC, 32'hFFFF_FFFF);
        m_flag[7:4] = '0; m_irq[7:4] = '0;
        rd("R5", 4'h4, 32'h0);
    endtask

    initial begin : watchdog
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_low_word();
        t_partial_clear();
        t_high_no_irq();
        t_mixed_enable();
        t_status_write();
        t_clear_reads_zero();
        t_collision();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule